// File: doc/BRIEF.md
# Bounds-Checked Descriptor Address Unit

This block turns a packed 64-bit data descriptor and an optional index value into the secondary memory address of one element of an array or byte string. The descriptor carries a type field, a bound (for strings, the byte count) and an origin byte address. Given these, the unit scales the index by the element width, adds it to the origin, and returns the address of the 64-bit word that holds the element plus the bit position inside that word.

Every indexed access is range checked in hardware. The check runs in the same cycle as the address sum, so it costs no extra latency. An index that is negative, or not below the bound, raises a fault and withholds the address. An access without an index uses element zero and skips the check. A vector descriptor whose size code is reserved raises a type fault. The unit has one register stage and accepts a new request every cycle.

Top module: `desc_addr_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all outputs are zero.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. In cycles without a response, every other output is zero.
- R3: Descriptor layout: bits 63:56 form the type field, bits 55:32 the bound/length, and bits 31:0 the origin byte address. Type bit 63 = 1 marks a vector and 0 marks a byte string. `is_vector` reports this bit with the response.
- R4: For a vector, type bits 58:56 give the element width as 2^code bits for codes 0 to 6 (1 to 64 bits). Code 7 raises `type_fault`. String descriptors never raise `type_fault`, and all other type bits are ignored.
- R5: For a string, the element bit address is (origin + index) * 8. The bound field is the byte count.
- R6: For a vector, the element bit address is origin * 8 + (index << code). `word_addr` is the bit address divided by 64 (30 bits) and `bit_off` is its low 6 bits.
- R7: When `modified` is high, `bound_fault` is raised if the 32-bit two's-complement `index` is negative or is greater than or equal to the bound field. This applies to both descriptor kinds.
- R8: `addr_valid` is high only for a response with neither fault. When it is low, `word_addr` and `bit_off` are zero.
- R9: When `modified` is low, `index` is ignored and treated as zero, and `bound_fault` stays low even when the bound field is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| desc | input | 64 | Packed descriptor: type, bound, origin |
| modified | input | 1 | Access is indexed by `index` |
| index | input | 32 | Signed modifier from the index register |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| addr_valid | output | 1 | Address is usable (no fault) |
| word_addr | output | 30 | Address of the 64-bit word holding the element |
| bit_off | output | 6 | Bit position of the element within that word |
| bound_fault | output | 1 | Index outside the range 0 to bound-1 |
| type_fault | output | 1 | Reserved vector element-size code |
| is_vector | output | 1 | Descriptor was a vector |

## Verification
Every result (the address, the bit offset, both faults and the kind flag) appears exactly one clock edge after its request is accepted. The bench drives a request on a falling edge and compares all outputs at the next falling edge against a reference function of the requirements. On that same falling edge it either releases the request or drives an idle cycle. The idle cycles test that a response lasts a single cycle and that all outputs return to zero. Random descriptors concentrate their index values around each bound, and directed cases cover the edges: an index equal to the bound, the last legal index, a negative index, a zero bound, an unindexed access, and the reserved size code.

// File: rtl/desc_pkg.sv
package desc_pkg;

    typedef enum logic {
        KIND_STRING = 1'b0,
        KIND_VECTOR = 1'b1
    } desc_kind_e;

    // Width of the element-size code held in the low type bits
    localparam int unsigned SIZE_CODE_W = 3;
    // Reserved element-size code
    localparam logic [SIZE_CODE_W-1:0] SIZE_CODE_RSVD = 3'd7;
    // Strings address bytes: shift of 3 (8 bits per element)
    localparam logic [SIZE_CODE_W-1:0] SIZE_CODE_BYTE = 3'd3;

endpackage

// File: rtl/desc_field_split.sv
module desc_field_split
    import desc_pkg::*;
#(
    parameter int unsigned TYP_W = 8,
    parameter int unsigned BND_W = 24,
    parameter int unsigned ORG_W = 32,
    localparam int unsigned DESC_W = TYP_W + BND_W + ORG_W
) (
    input  logic [DESC_W-1:0]      desc,
    output desc_kind_e             kind,
    output logic [SIZE_CODE_W-1:0] shift,
    output logic                   type_bad,
    output logic [BND_W-1:0]       bound,
    output logic [ORG_W-1:0]       origin
);
    logic [TYP_W-1:0]       type_f;
    logic [SIZE_CODE_W-1:0] code;

    always_comb begin
        type_f = desc[DESC_W-1 -: TYP_W];
        bound  = desc[ORG_W +: BND_W];
        origin = desc[ORG_W-1:0];
        code   = type_f[SIZE_CODE_W-1:0];
        kind   = type_f[TYP_W-1] ? KIND_VECTOR : KIND_STRING;
        if (kind == KIND_VECTOR) begin
            shift    = code;
            type_bad = (code == SIZE_CODE_RSVD);
        end else begin
            shift    = SIZE_CODE_BYTE;
            type_bad = 1'b0;
        end
    end
endmodule

// File: rtl/desc_bound_check.sv
module desc_bound_check #(
    parameter int unsigned MOD_W = 32,
    parameter int unsigned BND_W = 24
) (
    input  logic             modified,
    input  logic [MOD_W-1:0] index,
    input  logic [BND_W-1:0] bound,
    output logic             fault,
    output logic [BND_W-1:0] eff_index
);
    logic neg;
    logic too_big;

    always_comb begin
        neg       = index[MOD_W-1];
        too_big   = (index >= MOD_W'(bound));
        fault     = modified && (neg || too_big);
        eff_index = modified ? index[BND_W-1:0] : '0;
    end
endmodule

// File: rtl/desc_bit_addr.sv
module desc_bit_addr #(
    parameter int unsigned ORG_W  = 32,
    parameter int unsigned BND_W  = 24,
    parameter int unsigned SH_W   = 3,
    parameter int unsigned OFF_W  = 6,
    localparam int unsigned BA_W  = ORG_W + 4,
    localparam int unsigned WA_W  = BA_W - OFF_W
) (
    input  logic [ORG_W-1:0] origin,
    input  logic [BND_W-1:0] eff_index,
    input  logic [SH_W-1:0]  shift,
    output logic [WA_W-1:0]  word_addr,
    output logic [OFF_W-1:0] bit_off
);
    logic [BA_W-1:0] base_bits;
    logic [BA_W-1:0] scaled;
    logic [BA_W-1:0] bit_addr;

    always_comb begin
        base_bits = {1'b0, origin, 3'b000};
        scaled    = BA_W'(eff_index) << shift;
        bit_addr  = base_bits + scaled;
        word_addr = bit_addr[BA_W-1:OFF_W];
        bit_off   = bit_addr[OFF_W-1:0];
    end
endmodule

// File: rtl/desc_addr_unit.sv
module desc_addr_unit
    import desc_pkg::*;
#(
    parameter int unsigned TYP_W     = 8,
    parameter int unsigned BND_W     = 24,
    parameter int unsigned ORG_W     = 32,
    parameter int unsigned MOD_W     = 32,
    parameter int unsigned WORD_BITS = 64,
    localparam int unsigned DESC_W   = TYP_W + BND_W + ORG_W,
    localparam int unsigned OFF_W    = $clog2(WORD_BITS),
    localparam int unsigned WA_W     = ORG_W + 4 - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DESC_W-1:0] desc,
    input  logic              modified,
    input  logic [MOD_W-1:0]  index,
    output logic              rsp_valid,
    output logic              addr_valid,
    output logic [WA_W-1:0]   word_addr,
    output logic [OFF_W-1:0]  bit_off,
    output logic              bound_fault,
    output logic              type_fault,
    output logic              is_vector
);
    typedef struct packed {
        logic             rsp;
        logic             ok;
        logic [WA_W-1:0]  waddr;
        logic [OFF_W-1:0] boff;
        logic             bfault;
        logic             tfault;
        logic             vec;
    } rsp_t;

    desc_kind_e             kind;
    logic [SIZE_CODE_W-1:0] shift;
    logic                   type_bad;
    logic [BND_W-1:0]       bound;
    logic [ORG_W-1:0]       origin;
    logic                   bfault;
    logic [BND_W-1:0]       eff_index;
    logic [WA_W-1:0]        waddr_c;
    logic [OFF_W-1:0]       boff_c;

    rsp_t st_d, st_q;

    desc_field_split #(.TYP_W(TYP_W), .BND_W(BND_W), .ORG_W(ORG_W)) u_split (
        .desc     (desc),
        .kind     (kind),
        .shift    (shift),
        .type_bad (type_bad),
        .bound    (bound),
        .origin   (origin)
    );

    desc_bound_check #(.MOD_W(MOD_W), .BND_W(BND_W)) u_bchk (
        .modified  (modified),
        .index     (index),
        .bound     (bound),
        .fault     (bfault),
        .eff_index (eff_index)
    );

    desc_bit_addr #(.ORG_W(ORG_W), .BND_W(BND_W), .SH_W(SIZE_CODE_W), .OFF_W(OFF_W)) u_addr (
        .origin    (origin),
        .eff_index (eff_index),
        .shift     (shift),
        .word_addr (waddr_c),
        .bit_off   (boff_c)
    );

    always_comb begin
        st_d     = '0;
        st_d.rsp = req_valid;
        if (req_valid) begin
            st_d.bfault = bfault;
            st_d.tfault = type_bad;
            st_d.vec    = (kind == KIND_VECTOR);
            st_d.ok     = !bfault && !type_bad;
            if (st_d.ok) begin
                st_d.waddr = waddr_c;
                st_d.boff  = boff_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid   = st_q.rsp;
    assign addr_valid  = st_q.ok;
    assign word_addr   = st_q.waddr;
    assign bit_off     = st_q.boff;
    assign bound_fault = st_q.bfault;
    assign type_fault  = st_q.tfault;
    assign is_vector   = st_q.vec;
endmodule

// File: rtl/desc_addr_unit_chk.sv
module desc_addr_unit_chk #(
    parameter int unsigned TYP_W     = 8,
    parameter int unsigned BND_W     = 24,
    parameter int unsigned ORG_W     = 32,
    parameter int unsigned MOD_W     = 32,
    parameter int unsigned WORD_BITS = 64,
    localparam int unsigned DESC_W   = TYP_W + BND_W + ORG_W,
    localparam int unsigned OFF_W    = $clog2(WORD_BITS),
    localparam int unsigned WA_W     = ORG_W + 4 - OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [DESC_W-1:0] desc,
    input logic              modified,
    input logic [MOD_W-1:0]  index,
    input logic              rsp_valid,
    input logic              addr_valid,
    input logic [WA_W-1:0]   word_addr,
    input logic [OFF_W-1:0]  bit_off,
    input logic              bound_fault,
    input logic              type_fault,
    input logic              is_vector
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !bound_fault && !type_fault && !is_vector); // R2
    AST_ADDR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> rsp_valid && !bound_fault && !type_fault); // R8
    AST_SUPPRESSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (word_addr == '0) && (bit_off == '0)); // R8
    AST_NEG_INDEX_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && modified && index[MOD_W-1] |=> bound_fault); // R7
    AST_UNMOD_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !modified |=> !bound_fault); // R9
    AST_RSVD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && desc[DESC_W-1] && (desc[DESC_W-TYP_W +: 3] == 3'd7) |=> type_fault); // R4
    AST_STRING_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !desc[DESC_W-1] |=> !is_vector && !type_fault); // R3
endmodule

bind desc_addr_unit desc_addr_unit_chk #(
    .TYP_W(TYP_W), .BND_W(BND_W), .ORG_W(ORG_W), .MOD_W(MOD_W), .WORD_BITS(WORD_BITS)
) u_chk (.*);

// File: tb/sim_desc_addr_unit.sv
module sim_desc_addr_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [63:0] desc;
    logic        modified;
    logic [31:0] index;
    logic        rsp_valid, addr_valid, bound_fault, type_fault, is_vector;
    logic [29:0] word_addr;
    logic [5:0]  bit_off;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .desc(desc),
        .modified(modified), .index(index), .rsp_valid(rsp_valid),
        .addr_valid(addr_valid), .word_addr(word_addr), .bit_off(bit_off),
        .bound_fault(bound_fault), .type_fault(type_fault), .is_vector(is_vector)
    );

    // Packed response: rsp, ok, waddr(30), boff(6), bfault, tfault, vec = 41 bits
    function automatic logic [40:0] model(input logic [63:0] d, input logic m,
                                          input logic [31:0] ix);
        logic        vec, tf, bf, ok;
        logic [2:0]  sh;
        logic [63:0] ba;
        logic [63:0] ixe;
        logic [29:0] wa;
        logic [5:0]  bo;
        vec = d[63];
        sh  = vec ? d[58:56] : 3'd3;
        tf  = vec && (d[58:56] == 3'd7);
        bf  = m && (ix[31] || (ix >= {8'd0, d[55:32]}));
        ok  = !tf && !bf;
        ixe = m ? {32'd0, ix} : 64'd0;
        ba  = ({32'd0, d[31:0]} << 3) + (ixe << sh);
        wa  = ok ? ba[35:6] : 30'd0;
        bo  = ok ? ba[5:0] : 6'd0;
        return {1'b1, ok, wa, bo, bf, tf, vec};
    endfunction

    function automatic logic [63:0] mk(input logic v, input logic [2:0] c,
                                       input logic [23:0] b, input logic [31:0] o);
        return {v, 4'b0101, c, b, o};
    endfunction

    task automatic compare(input logic [40:0] exp, input string tag);
        logic [40:0] act;
        act = {rsp_valid, addr_valid, word_addr, bit_off, bound_fault, type_fault, is_vector};
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xact(input logic [63:0] d, input logic m, input logic [31:0] ix,
                        input string tag);
        @(negedge clk);
        req_valid = 1'b1; desc = d; modified = m; index = ix;
        @(negedge clk);
        req_valid = 1'b0; desc = ~d; index = ~ix;
        compare(model(d, m, ix), tag);
    endtask

    task automatic idle_check;
        @(negedge clk);
        compare(41'd0, "R2 idle");
    endtask

    initial begin
        logic [40:0] e;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; desc = '0; modified = 1'b0; index = '0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; desc = mk(1'b1, 3'd2, 24'd5, 32'h100);
        @(negedge clk);
        compare(41'd0, "R1 in reset");
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        compare(41'd0, "R1 after reset");

        // Directed corners
        xact(mk(1'b0, 3'd0, 24'd10, 32'h0000_1003), 1'b1, 32'd4, "R5 string R3");
        xact(mk(1'b1, 3'd5, 24'd8, 32'h0000_2000), 1'b1, 32'd7, "R6 last legal");
        xact(mk(1'b1, 3'd5, 24'd8, 32'h0000_2000), 1'b1, 32'd8, "R7 index==bound R8");
        xact(mk(1'b1, 3'd0, 24'd8, 32'h0000_2000), 1'b1, 32'hFFFF_FFFF, "R7 negative");
        xact(mk(1'b0, 3'd1, 24'd0, 32'h0000_0040), 1'b1, 32'd0, "R7 zero bound");
        xact(mk(1'b1, 3'd6, 24'd0, 32'h0000_0040), 1'b0, 32'h8000_0000, "R9 unmodified");
        xact(mk(1'b1, 3'd7, 24'd100, 32'h0000_0040), 1'b1, 32'd3, "R4 reserved code");
        xact(mk(1'b0, 3'd7, 24'd100, 32'h0000_0040), 1'b1, 32'd3, "R4 string code7");
        xact(mk(1'b1, 3'd0, 24'hFF_FFFF, 32'hFFFF_FFFF), 1'b1, 32'h00FF_FFFE, "R6 max range");
        for (int c = 0; c < 7; c++)
            xact(mk(1'b1, 3'(c), 24'd200, 32'h0000_0123), 1'b1, 32'd77, "R6 size code");
        idle_check();

        // Back-to-back pair: second response must follow the first directly
        @(negedge clk);
        req_valid = 1'b1; desc = mk(1'b1, 3'd3, 24'd9, 32'h10); modified = 1'b1; index = 32'd2;
        @(negedge clk);
        e = model(desc, modified, index);
        compare(e, "R2 back-to-back first");
        desc = mk(1'b0, 3'd0, 24'd9, 32'h20); index = 32'd9;
        @(negedge clk);
        req_valid = 1'b0;
        compare(model(mk(1'b0, 3'd0, 24'd9, 32'h20), 1'b1, 32'd9), "R2 back-to-back second R7");
        idle_check();

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [63:0] d;
            logic [23:0] b;
            logic [31:0] ix;
            logic        m;
            logic [40:0] x;
            string       tag;
            b  = ($urandom % 4 == 0) ? 24'($urandom) : 24'($urandom % 64);
            d  = {1'($urandom), 4'($urandom), 3'($urandom), b, 32'($urandom)};
            m  = ($urandom % 4) != 0;
            case ($urandom % 5)
                0: ix = {8'd0, b} - 32'd1;
                1: ix = {8'd0, b};
                2: ix = 32'($urandom);
                default: ix = 32'($urandom % ({8'd0, b} + 32'd2));
            endcase
            x = model(d, m, ix);
            if (x[1])                tag = "R4 random";
            else if (x[2])           tag = "R7 random";
            else if (!m)             tag = "R9 random";
            else if (d[63])          tag = "R6 random";
            else                     tag = "R5 random";
            xact(d, m, ix, tag);
            if (i % 50 == 0) idle_check();
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule